// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Address Decoder

This block sits between an 8-bit processor with a 16-bit address space and its memories and peripherals. The processor shares its low address byte with the data bus; the block captures that byte on the address strobe and keeps it while the same wires carry data. The captured byte is joined with the separately driven high address byte to give a full address.

From that address, the memory/IO status line and the read and write strobes, the block produces active-low chip selects for a boot ROM (bottom quarter of memory), a RAM (upper half of memory), a keyboard/display controller, a parallel port device, an interval timer and one spare I/O slot. I/O devices are picked by the top two bits of the 8-bit port address. A small register-select field gives each I/O device its low address bits. The block also steers the selected device's read data toward the processor, with a separate output enable that models the shared bus being released, and forwards the selected device's ready line so a slow device can stretch the access.

Top module: `mbus_demux_dec`

## Requirements
- R1: When `ale` is high at a rising clock edge, `addr_o[7:0]` takes the value of `ad_in` from the next cycle on; while `ale` is low the latched byte does not change, whatever `ad_in` does. `addr_o[15:8]` always equals `addr_hi`.
- R2: After reset, `addr_o[7:0]` is zero and every bit of `cs_n` is high until a first address strobe has been captured, even if a read or write strobe is asserted.
- R3: No select asserts unless `rd_n` or `wr_n` is low; with both high, `cs_n` is all ones.
- R4: In a memory cycle (`io_m`=0) with address bits [15:14]=00, only `cs_n[0]` (ROM) is low.
- R5: In a memory cycle, address bits [15:14]=10 or 11 drive only `cs_n[1]` (RAM) low; bits 01 leave every select high.
- R6: In an I/O cycle (`io_m`=1) the latched port byte bits [7:6] select: 00 → `cs_n[2]` (keyboard/display), 01 → `cs_n[3]` (parallel port), 10 → `cs_n[4]` (timer), 11 → `cs_n[5]` (spare); `cs_n[1:0]` stay high.
- R7: In a memory cycle, `cs_n[5:2]` all stay high.
- R8: At most one bit of `cs_n` is low at any time.
- R9: `regsel_o` is port bit 0 (upper bit zero) for the keyboard/display, port bits [1:0] for the other three I/O selects, and 00 when no I/O select is active.
- R10: `dout_oe` is high only while `rd_n` is low and a select is active; then `dout_o` equals the byte of the selected device in `dev_rdata` (device i at bits [8i+7:8i]); otherwise `dout_o` is zero.
- R11: `cpu_ready` equals `dev_ready[i]` of the selected device i, and is high when no select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 8 | Multiplexed low address / data byte from the processor |
| addr_hi | input | 8 | High address byte |
| ale | input | 1 | Address strobe, high while the low byte holds an address |
| io_m | input | 1 | Space type: 0 memory, 1 I/O |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| dev_rdata | input | 48 | Read data of the six devices, device i at [8i+7:8i] |
| dev_ready | input | 6 | Ready line of each device |
| addr_o | output | 16 | Demultiplexed full address |
| cs_n | output | 6 | Active-low selects: 0 ROM, 1 RAM, 2 keyboard/display, 3 parallel, 4 timer, 5 spare |
| regsel_o | output | 2 | Register select for the selected I/O device |
| dout_o | output | 8 | Read data toward the processor |
| dout_oe | output | 1 | Drive enable for `dout_o`; low means the bus is released |
| cpu_ready | output | 1 | Ready toward the processor |

## Verification
The bench builds the block with its default parameters: an 8-bit data byte, a 16-bit address and two port-group bits, which gives exactly the four memory quadrants and four I/O groups of the map. With those values every quadrant and every port group is reachable in both space types, so directed passes cross all eight combinations with reads, writes and idle strobes, and random cycles add arbitrary low bits, read data and ready patterns. The reset window before the first address strobe and the latch hold while the bus carries data are driven as separate corner cases.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    // Index of each device in the select, read-data and ready vectors.
    localparam int DEV_ROM   = 0;
    localparam int DEV_RAM   = 1;
    localparam int DEV_KBD   = 2;
    localparam int DEV_PAR   = 3;
    localparam int DEV_TMR   = 4;
    localparam int DEV_SPARE = 5;
    localparam int NMEM      = 2;
    localparam int RSW       = 2;

    // Top two address bits of a memory cycle.
    typedef enum logic [1:0] {
        Q_ROM  = 2'b00,
        Q_GAP  = 2'b01,
        Q_RAM0 = 2'b10,
        Q_RAM1 = 2'b11
    } quad_e;
endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] lo_q,
    output logic          valid_q
);
    typedef struct packed {
        logic [DW-1:0] lo;
        logic          valid;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ale) begin
            st_d.lo    = ad_in;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_q    = st_q.lo;
    assign valid_q = st_q.valid;
endmodule

// File: rtl/mbus_space_dec.sv
module mbus_space_dec
    import mbus_pkg::*;
#(
    parameter int PSB  = 2,
    localparam int NIO  = 2 ** PSB,
    localparam int NDEV = NMEM + NIO
) (
    input  logic            valid,
    input  logic            io_m,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [1:0]      mem_top,
    input  logic [PSB-1:0]  port_top,
    input  logic [RSW-1:0]  port_reg,
    output logic [NDEV-1:0] cs_n,
    output logic [RSW-1:0]  regsel
);
    logic            strobe;
    logic [NDEV-1:0] hit;

    assign strobe = valid & (~rd_n | ~wr_n);

    always_comb begin
        hit[DEV_ROM] = strobe & ~io_m & (quad_e'(mem_top) == Q_ROM);
        hit[DEV_RAM] = strobe & ~io_m & ((quad_e'(mem_top) == Q_RAM0) ||
                                         (quad_e'(mem_top) == Q_RAM1));
    end

    for (genvar g = 0; g < NIO; g++) begin : g_io
        assign hit[NMEM+g] = strobe & io_m & (port_top == PSB'(g));
    end

    assign cs_n = ~hit;

    always_comb begin
        regsel = '0;
        if (hit[DEV_KBD])              regsel = {1'b0, port_reg[0]};
        else if (|hit[NDEV-1:NMEM])    regsel = port_reg;
    end
endmodule

// File: rtl/mbus_rd_mux.sv
module mbus_rd_mux #(
    parameter int DW   = 8,
    parameter int NDEV = 6
) (
    input  logic [NDEV-1:0]    cs_n,
    input  logic               rd_n,
    input  logic [NDEV*DW-1:0] dev_rdata,
    input  logic [NDEV-1:0]    dev_ready,
    output logic [DW-1:0]      dout,
    output logic               oe,
    output logic               ready
);
    logic          any_sel;
    logic [DW-1:0] pick;
    logic          rdy_pick;

    always_comb begin
        pick     = '0;
        rdy_pick = 1'b0;
        for (int i = 0; i < NDEV; i++) begin
            if (!cs_n[i]) begin
                pick     = pick | dev_rdata[i*DW +: DW];
                rdy_pick = rdy_pick | dev_ready[i];
            end
        end
    end

    assign any_sel = ~&cs_n;
    assign oe      = any_sel & ~rd_n;
    assign dout    = oe ? pick : '0;
    assign ready   = any_sel ? rdy_pick : 1'b1;
endmodule

// File: rtl/mbus_demux_dec.sv
module mbus_demux_dec
    import mbus_pkg::*;
#(
    parameter int DW  = 8,
    parameter int AW  = 16,
    parameter int PSB = 2,
    localparam int NDEV = NMEM + 2 ** PSB,
    localparam int HW   = AW - DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DW-1:0]      ad_in,
    input  logic [HW-1:0]      addr_hi,
    input  logic               ale,
    input  logic               io_m,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic [NDEV*DW-1:0] dev_rdata,
    input  logic [NDEV-1:0]    dev_ready,
    output logic [AW-1:0]      addr_o,
    output logic [NDEV-1:0]    cs_n,
    output logic [RSW-1:0]     regsel_o,
    output logic [DW-1:0]      dout_o,
    output logic               dout_oe,
    output logic               cpu_ready
);
    logic [DW-1:0] lo_q;
    logic          valid_q;

    mbus_addr_latch #(.DW(DW)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ale     (ale),
        .ad_in   (ad_in),
        .lo_q    (lo_q),
        .valid_q (valid_q)
    );

    assign addr_o = {addr_hi, lo_q};

    mbus_space_dec #(.PSB(PSB)) u_dec (
        .valid    (valid_q),
        .io_m     (io_m),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .mem_top  (addr_hi[HW-1 -: 2]),
        .port_top (lo_q[DW-1 -: PSB]),
        .port_reg (lo_q[RSW-1:0]),
        .cs_n     (cs_n),
        .regsel   (regsel_o)
    );

    mbus_rd_mux #(.DW(DW), .NDEV(NDEV)) u_mux (
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .dev_rdata (dev_rdata),
        .dev_ready (dev_ready),
        .dout      (dout_o),
        .oe        (dout_oe),
        .ready     (cpu_ready)
    );
endmodule

// File: rtl/mbus_demux_dec_chk.sv
module mbus_demux_dec_chk #(
    parameter int DW   = 8,
    parameter int AW   = 16,
    parameter int NDEV = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ale,
    input logic [DW-1:0]   ad_in,
    input logic            io_m,
    input logic            rd_n,
    input logic            wr_n,
    input logic [AW-1:0]   addr_o,
    input logic [NDEV-1:0] cs_n,
    input logic            dout_oe
);
    // R8
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R6
    io_keeps_mem_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_m |-> &cs_n[1:0]);

    // R7
    mem_keeps_io_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_m |-> &cs_n[NDEV-1:2]);

    // R3
    idle_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n) |-> &cs_n);

    // R5
    gap_quadrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_m && addr_o[AW-1 -: 2] == 2'b01) |-> &cs_n);

    // R10
    drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> !rd_n);

    // R1
    latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> addr_o[DW-1:0] == $past(ad_in));

    // R1
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(addr_o[DW-1:0]));
endmodule

bind mbus_demux_dec mbus_demux_dec_chk #(.DW(DW), .AW(AW), .NDEV(NDEV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale     (ale),
    .ad_in   (ad_in),
    .io_m    (io_m),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr_o  (addr_o),
    .cs_n    (cs_n),
    .dout_oe (dout_oe)
);

// File: tb/sim_mbus_demux_dec.sv
`timescale 1ns/1ps
module sim_mbus_demux_dec;
    localparam int NDEV = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      ad_in = '0;
    logic [7:0]      addr_hi = '0;
    logic            ale = 1'b0;
    logic            io_m = 1'b0;
    logic            rd_n = 1'b1;
    logic            wr_n = 1'b1;
    logic [47:0]     dev_rdata = '0;
    logic [5:0]      dev_ready = '1;
    logic [15:0]     addr_o;
    logic [5:0]      cs_n;
    logic [1:0]      regsel_o;
    logic [7:0]      dout_o;
    logic            dout_oe;
    logic            cpu_ready;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mbus_demux_dec u0 (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .addr_hi(addr_hi), .ale(ale),
        .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .dev_rdata(dev_rdata),
        .dev_ready(dev_ready), .addr_o(addr_o), .cs_n(cs_n), .regsel_o(regsel_o),
        .dout_o(dout_o), .dout_oe(dout_oe), .cpu_ready(cpu_ready)
    );

    task automatic chk(input string req, input string what, input logic [47:0] act,
                       input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Index of the expected select, or -1 for none.
    function automatic int exp_sel(input bit valid, input logic [7:0] lo,
                                   input logic [7:0] hi, input bit io,
                                   input bit rd, input bit wr);
        if (!valid || (rd && wr)) return -1;
        if (io) return 2 + int'(lo[7:6]);
        case (hi[7:6])
            2'b00:   return 0;
            2'b01:   return -1;
            default: return 1;
        endcase
    endfunction

    function automatic logic [5:0] exp_cs(input int s);
        logic [5:0] m = 6'h3F;
        if (s >= 0) m[s] = 1'b0;
        return m;
    endfunction

    function automatic logic [1:0] exp_rs(input int s, input logic [7:0] lo);
        if (s == 2) return {1'b0, lo[0]};
        if (s >= 3) return lo[1:0];
        return 2'b00;
    endfunction

    function automatic string sel_req(input int s, input bit io, input logic [7:0] hi,
                                      input bit rd, input bit wr);
        if (rd && wr) return "R3";
        if (io) return "R6";
        if (hi[7:6] == 2'b00) return "R4";
        return "R5";
    endfunction

    // One bus cycle: address phase with ale, then a strobe phase.
    task automatic bus_cycle(input logic [7:0] lo, input logic [7:0] hi, input bit io,
                             input bit rd, input bit wr);
        int s;
        logic [7:0] exp_d;
        @(negedge clk);
        ale = 1'b1; ad_in = lo; addr_hi = hi; io_m = io; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        ale = 1'b0; ad_in = 8'($urandom);
        rd_n = rd; wr_n = wr;
        dev_rdata = {16'($urandom), 32'($urandom)};
        dev_ready = 6'($urandom);
        #5;
        s = exp_sel(1'b1, lo, hi, io, rd, wr);
        chk("R1", "address", 48'(addr_o), 48'({hi, lo}));
        chk(sel_req(s, io, hi, rd, wr), "selects", 48'(cs_n), 48'(exp_cs(s)));
        chk("R8", "select count", 48'($countones(~cs_n) <= 1), 48'(1));
        if (!io) chk("R7", "io selects in mem cycle", 48'(cs_n[5:2]), 48'(4'hF));
        chk("R9", "regsel", 48'(regsel_o), 48'(exp_rs(s, lo)));
        exp_d = (s >= 0 && !rd) ? dev_rdata[s*8 +: 8] : 8'h00;
        chk("R10", "oe", 48'(dout_oe), 48'(s >= 0 && !rd));
        chk("R10", "dout", 48'(dout_o), 48'(exp_d));
        chk("R11", "ready", 48'(cpu_ready), 48'((s >= 0) ? dev_ready[s] : 1'b1));
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        // R2: reset state and the window before the first address strobe
        #35;
        chk("R2", "reset latch", 48'(addr_o[7:0]), 48'(0));
        chk("R2", "reset selects", 48'(cs_n), 48'(6'h3F));
        @(negedge clk); rst_n = 1'b1;
        ad_in = 8'hC5; io_m = 1'b1; rd_n = 1'b0;
        @(negedge clk); #5;
        chk("R2", "selects before first strobe", 48'(cs_n), 48'(6'h3F));
        chk("R2", "latch before first strobe", 48'(addr_o[7:0]), 48'(0));
        chk("R10", "oe before first strobe", 48'(dout_oe), 48'(0));
        rd_n = 1'b1;

        // Directed: every quadrant and port group in both spaces
        for (int q = 0; q < 4; q++) begin
            for (int io = 0; io < 2; io++) begin
                logic [7:0] b = {2'(q), 6'h03};
                bus_cycle(b, io ? b : {2'(q), 6'h2A}, 1'(io), 1'b0, 1'b1);
                bus_cycle(b ^ 8'h01, io ? (b ^ 8'h01) : {2'(q), 6'h11}, 1'(io), 1'b1, 1'b0);
                bus_cycle(b, b, 1'(io), 1'b1, 1'b1);
            end
        end

        // R1: latch holds while the bus carries data
        @(negedge clk); ale = 1'b1; ad_in = 8'h42; addr_hi = 8'h42; io_m = 1'b1;
        @(negedge clk); ale = 1'b0; rd_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            ad_in = 8'($urandom);
            @(negedge clk); #5;
            chk("R1", "hold while ale low", 48'(addr_o[7:0]), 48'(8'h42));
            chk("R9", "regsel during hold", 48'(regsel_o), 48'(2'b10));
        end
        rd_n = 1'b1;

        // R11: slow device holds ready low
        @(negedge clk); ale = 1'b1; ad_in = 8'h81; addr_hi = 8'h81; io_m = 1'b1;
        @(negedge clk); ale = 1'b0; rd_n = 1'b0; dev_ready = 6'b101111;
        #5;
        chk("R11", "timer not ready", 48'(cpu_ready), 48'(0));
        @(negedge clk); dev_ready = 6'b111111; #5;
        chk("R11", "timer ready", 48'(cpu_ready), 48'(1));
        rd_n = 1'b1;

        // Random cycles
        for (int n = 0; n < 400; n++) begin
            bit io = 1'($urandom);
            logic [7:0] lo = 8'($urandom);
            logic [7:0] hi = io ? lo : 8'($urandom);
            int strb = $urandom_range(0, 2);
            bus_cycle(lo, hi, io, strb != 0, strb != 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1;
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule